// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block performs the work triggered when a new selector is written into a segment register. It splits the 16-bit selector into a table index, a table-select bit and a requested privilege. It checks the selector against the bounds of the chosen descriptor table. If the checks pass, it fetches the 8-byte descriptor with two 32-bit reads. It then unpacks the scattered base, limit, flag and access fields into a hidden per-segment cache. Later accesses read this cache through a query port, so the table is never fetched again until the selector changes.

The block keeps the global table base and limit, which software writes directly. It also keeps a cached base and limit for the local table. That pair is loaded through the same engine from an entry of the global table. Segment 0 is the code segment and segment 1 is the stack segment. Segments 2 and up are data segments. Every load ends in a one-cycle completion pulse that carries a fault code. While a load is in flight, the target segment's busy bit stalls its users.

The controller is a five-state machine:
- ST_IDLE accepts a request.
- ST_IDLE goes to ST_DONE for a load that needs no fetch (a fault found before the fetch, or a null load).
- ST_IDLE goes to ST_FETCH_LO when a fetch is needed.
- ST_FETCH_LO goes to ST_FETCH_HI on the first read handshake.
- ST_FETCH_HI goes to ST_EVAL on the second read handshake.
- ST_EVAL always goes to ST_DONE. In that cycle it checks the present bit and privilege and commits the result.
- ST_DONE always returns to ST_IDLE.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset:
  - every cached segment is invalid;
  - the local table register is invalid;
  - `ld_ready` is 1;
  - `done`, `rd_valid` and `seg_busy` are 0.
- R2: A selector is decoded as index = bits 15:3, table select = bit 2 (0 global, 1 local) and requested privilege = bits 1:0. A fetch issues exactly two reads: first at table base + index*8, then at that address + 4. While `rd_valid` is high and `rd_ready` is low, the address holds.
- R3: A successful load caches the descriptor fields, read from the descriptor with byte 0 as the least significant byte of the first read word:
  - base = {byte7, byte4, byte3, byte2};
  - limit20 = {byte6[3:0], byte1, byte0};
  - access byte = byte5;
  - granularity = byte6 bit 7, default size = byte6 bit 6, available = byte6 bit 4.

  The query port reports the effective limit: {limit20, 12'hFFF} when granularity is 1, otherwise limit20 zero-extended.
- R4: A null selector (index 0, table select 0) loaded into segment 0 or 1 ends with fault code 1 and no reads. Loaded into a data segment, it ends with code 0 and no reads. It leaves that segment invalid, with the selector stored and all fields zero.
- R5: If index*8+7 exceeds the selected table limit, the load ends with fault code 2 and no reads. A local-table selector while the local table register is invalid also gives code 2.
- R6: A fetched descriptor whose access byte bit 7 (present) is 0 gives fault code 3.
- R7: For data segments only, max(CPL, RPL) greater than the descriptor privilege (access byte bits 6:5) gives fault code 4.
- R8: A faulting load leaves the target cache unchanged. Fault precedence is: null (1), then limit (2), then not present (3), then privilege (4).
- R9: A local-table-register load (`ld_to_ldt`) behaves as follows:
  - a selector with table select 1 gives code 5;
  - a null selector gives code 0 and makes the local table invalid;
  - otherwise the local table register loads the base and effective limit of the global entry, after the limit and present checks;
  - no segment cache changes.
- R10: From the cycle after acceptance through the completion cycle, `ld_ready` is 0 and only the target segment's `seg_busy` bit is 1. None is set for a local-table-register load. `ld_valid` during that time is ignored.
- R11: A global-table write in the same cycle as an accepted load does not affect that load. The load checks and fetches against the previous base and limit, and the new values apply from the next load.
- R12: Each accepted load gives exactly one single-cycle `done` pulse. In that cycle `fault` is 1 exactly when `fault_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_we | input | 1 | Write global table base and limit |
| gdt_base_in | input | 32 | New global table base |
| gdt_limit_in | input | 16 | New global table limit (last valid byte offset) |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Engine idle; request accepted when both are high |
| ld_to_ldt | input | 1 | Request targets the local table register |
| ld_seg | input | SEG_W | Target segment (0 code, 1 stack, 2+ data) |
| ld_sel | input | 16 | Selector to load |
| ld_cpl | input | 2 | Current privilege level |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 32 | Read data |
| done | output | 1 | Load complete (one cycle) |
| fault | output | 1 | Completed load faulted |
| fault_code | output | 3 | 0 ok, 1 null, 2 limit, 3 not present, 4 privilege, 5 bad table |
| seg_busy | output | NUM_SEGS | Per-segment load in progress |
| q_seg | input | SEG_W | Cache query index |
| q_valid | output | 1 | Queried segment holds a usable descriptor |
| q_sel | output | 16 | Queried selector |
| q_base | output | 32 | Queried base |
| q_limit | output | 32 | Queried effective limit |
| q_access | output | 8 | Queried access byte |
| q_gran | output | 1 | Queried granularity flag |
| q_dbit | output | 1 | Queried default-size flag |
| q_avail | output | 1 | Queried available flag |
| ldt_valid | output | 1 | Local table register loaded |
| ldt_base | output | 32 | Local table base |
| ldt_limit | output | 32 | Local table effective limit |

## Verification
Two events can fall in the same clock edge: a software write of the global table registers and the acceptance of a load that reads those registers. The bench drives both on one edge. It shrinks the limit so that the in-flight load would fault under the new value but succeed under the old one. It then requires that load to succeed and the following load of the same selector to fault. A second overlap puts a request on `ld_valid` while a fetch is stalled. It is judged by counting completion pulses and confirming that the other segment's cache is untouched.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    // Unpacked descriptor as held in a hidden segment cache.
    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic [7:0]  acc;
        logic        gran;
        logic        dbit;
        logic        avail;
    } desc_t;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_ABSENT = 3'd3,
        FLT_PRIV   = 3'd4,
        FLT_TABLE  = 3'd5
    } fault_e;

    // Effective last offset of a segment, scaled by 4 KiB pages when granular.
    function automatic logic [31:0] span_of(input desc_t d);
        return d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
    endfunction

endpackage

// File: rtl/sdl_selchk.sv
module sdl_selchk
    import sdl_pkg::*;
(
    input  logic [15:0] sel,
    input  logic        to_ldt,
    input  logic        sys_seg,
    input  logic [31:0] gdt_base,
    input  logic [15:0] gdt_limit,
    input  logic        ldt_ok,
    input  logic [31:0] ldt_base,
    input  logic [31:0] ldt_limit,
    output logic [31:0] desc_addr,
    output fault_e      early_flt,
    output logic        null_load
);

    logic [12:0] idx;
    logic        ti;
    logic        is_null;
    logic [15:0] last_byte;
    logic [31:0] offs;

    assign idx       = sel[15:3];
    assign ti        = sel[2];
    assign is_null   = (idx == 13'd0) && !ti;
    assign last_byte = {idx, 3'b111};
    assign offs      = {16'h0000, idx, 3'b000};

    always_comb begin
        desc_addr = ti ? (ldt_base + offs) : (gdt_base + offs);
        early_flt = FLT_NONE;
        null_load = 1'b0;
        if (to_ldt) begin
            if (ti)                          early_flt = FLT_TABLE;
            else if (is_null)                null_load = 1'b1;
            else if (last_byte > gdt_limit)  early_flt = FLT_LIMIT;
        end else if (is_null) begin
            if (sys_seg) early_flt = FLT_NULL;
            else         null_load = 1'b1;
        end else if (ti) begin
            if (!ldt_ok || ({16'h0000, last_byte} > ldt_limit))
                early_flt = FLT_LIMIT;
        end else if (last_byte > gdt_limit) begin
            early_flt = FLT_LIMIT;
        end
    end

endmodule

// File: rtl/sdl_unpack.sv
module sdl_unpack
    import sdl_pkg::*;
(
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    output desc_t       desc
);

    // lo_word = bytes 3..0, hi_word = bytes 7..4 (byte 0 least significant)
    always_comb begin
        desc.limit = {hi_word[19:16], lo_word[15:0]};
        desc.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        desc.acc   = hi_word[15:8];
        desc.gran  = hi_word[23];
        desc.dbit  = hi_word[22];
        desc.avail = hi_word[20];
    end

endmodule

// File: rtl/sdl_cache.sv
module sdl_cache
    import sdl_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    parameter int SEG_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  logic             wvalid,
    input  logic [15:0]      wsel,
    input  desc_t            wdesc,
    input  logic [SEG_W-1:0] ridx,
    output logic             rvalid,
    output logic [15:0]      rsel,
    output desc_t            rdesc
);

    logic        ent_v [NUM_SEGS];
    logic [15:0] ent_s [NUM_SEGS];
    desc_t       ent_d [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
        logic        v_q;
        logic [15:0] s_q;
        desc_t       d_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                s_q <= 16'h0000;
                d_q <= '0;
            end else if (we && (widx == SEG_W'(g))) begin
                v_q <= wvalid;
                s_q <= wsel;
                d_q <= wdesc;
            end
        end

        assign ent_v[g] = v_q;
        assign ent_s[g] = s_q;
        assign ent_d[g] = d_q;
    end

    always_comb begin
        rvalid = ent_v[ridx];
        rsel   = ent_s[ridx];
        rdesc  = ent_d[ridx];
    end

endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import sdl_pkg::*;
#(
    parameter  int NUM_SEGS = 4,
    localparam int SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gdt_we,
    input  logic [31:0]         gdt_base_in,
    input  logic [15:0]         gdt_limit_in,
    input  logic                ld_valid,
    output logic                ld_ready,
    input  logic                ld_to_ldt,
    input  logic [SEG_W-1:0]    ld_seg,
    input  logic [15:0]         ld_sel,
    input  logic [1:0]          ld_cpl,
    output logic                rd_valid,
    output logic [31:0]         rd_addr,
    input  logic                rd_ready,
    input  logic [31:0]         rd_data,
    output logic                done,
    output logic                fault,
    output logic [2:0]          fault_code,
    output logic [NUM_SEGS-1:0] seg_busy,
    input  logic [SEG_W-1:0]    q_seg,
    output logic                q_valid,
    output logic [15:0]         q_sel,
    output logic [31:0]         q_base,
    output logic [31:0]         q_limit,
    output logic [7:0]          q_access,
    output logic                q_gran,
    output logic                q_dbit,
    output logic                q_avail,
    output logic                ldt_valid,
    output logic [31:0]         ldt_base,
    output logic [31:0]         ldt_limit
);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_EVAL,
        ST_DONE
    } st_e;

    st_e state, nstate;

    // table registers
    logic [31:0] gdt_base_q;
    logic [15:0] gdt_limit_q;
    logic        ldt_valid_q;
    logic [31:0] ldt_base_q;
    logic [31:0] ldt_limit_q;

    // request capture
    logic [SEG_W-1:0] tgt_seg_q;
    logic             tgt_ldt_q;
    logic [15:0]      tgt_sel_q;
    logic [1:0]       tgt_cpl_q;
    logic [31:0]      addr_q;
    logic [31:0]      lo_q;
    logic [31:0]      hi_q;
    fault_e           flt_q;

    logic        accept;
    logic        sys_seg;
    logic [31:0] desc_addr;
    fault_e      early_flt;
    logic        null_load;
    desc_t       fetched;
    fault_e      late_flt;
    logic [1:0]  eff_pl;

    logic             cw_en;
    logic [SEG_W-1:0] cw_idx;
    logic             cw_valid;
    logic [15:0]      cw_sel;
    desc_t            cw_desc;
    desc_t            q_desc;

    assign accept  = ld_valid && (state == ST_IDLE);
    assign sys_seg = (ld_seg <= SEG_W'(1));

    sdl_selchk u_selchk (
        .sel       (ld_sel),
        .to_ldt    (ld_to_ldt),
        .sys_seg   (sys_seg),
        .gdt_base  (gdt_base_q),
        .gdt_limit (gdt_limit_q),
        .ldt_ok    (ldt_valid_q),
        .ldt_base  (ldt_base_q),
        .ldt_limit (ldt_limit_q),
        .desc_addr (desc_addr),
        .early_flt (early_flt),
        .null_load (null_load)
    );

    sdl_unpack u_unpack (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .desc    (fetched)
    );

    // checks that need the fetched descriptor
    assign eff_pl = (tgt_cpl_q > tgt_sel_q[1:0]) ? tgt_cpl_q : tgt_sel_q[1:0];

    always_comb begin
        if (!fetched.acc[7])
            late_flt = FLT_ABSENT;
        else if (!tgt_ldt_q && (tgt_seg_q > SEG_W'(1)) && (eff_pl > fetched.acc[6:5]))
            late_flt = FLT_PRIV;
        else
            late_flt = FLT_NONE;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if ((early_flt != FLT_NONE) || null_load) nstate = ST_DONE;
                    else                                      nstate = ST_FETCH_LO;
                end
            end
            ST_FETCH_LO: if (rd_ready) nstate = ST_FETCH_HI;
            ST_FETCH_HI: if (rd_ready) nstate = ST_EVAL;
            ST_EVAL:     nstate = ST_DONE;
            ST_DONE:     nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gdt_base_q  <= 32'h0;
            gdt_limit_q <= 16'h0;
            ldt_valid_q <= 1'b0;
            ldt_base_q  <= 32'h0;
            ldt_limit_q <= 32'h0;
            tgt_seg_q   <= '0;
            tgt_ldt_q   <= 1'b0;
            tgt_sel_q   <= 16'h0;
            tgt_cpl_q   <= 2'd0;
            addr_q      <= 32'h0;
            lo_q        <= 32'h0;
            hi_q        <= 32'h0;
            flt_q       <= FLT_NONE;
        end else begin
            if (gdt_we) begin
                gdt_base_q  <= gdt_base_in;
                gdt_limit_q <= gdt_limit_in;
            end
            if (accept) begin
                tgt_seg_q <= ld_seg;
                tgt_ldt_q <= ld_to_ldt;
                tgt_sel_q <= ld_sel;
                tgt_cpl_q <= ld_cpl;
                addr_q    <= desc_addr;
                flt_q     <= early_flt;
                if (ld_to_ldt && null_load) begin
                    ldt_valid_q <= 1'b0;
                    ldt_base_q  <= 32'h0;
                    ldt_limit_q <= 32'h0;
                end
            end
            if ((state == ST_FETCH_LO) && rd_ready) lo_q <= rd_data;
            if ((state == ST_FETCH_HI) && rd_ready) hi_q <= rd_data;
            if (state == ST_EVAL) begin
                flt_q <= late_flt;
                if (tgt_ldt_q && (late_flt == FLT_NONE)) begin
                    ldt_valid_q <= 1'b1;
                    ldt_base_q  <= fetched.base;
                    ldt_limit_q <= span_of(fetched);
                end
            end
        end
    end

    // cache write port: null loads at acceptance, fetched loads at evaluation
    always_comb begin
        cw_en    = (accept && null_load && !ld_to_ldt)
                 || ((state == ST_EVAL) && !tgt_ldt_q && (late_flt == FLT_NONE));
        cw_idx   = (state == ST_IDLE) ? ld_seg : tgt_seg_q;
        cw_valid = (state != ST_IDLE);
        cw_sel   = (state == ST_IDLE) ? ld_sel : tgt_sel_q;
        cw_desc  = (state == ST_IDLE) ? desc_t'('0) : fetched;
    end

    sdl_cache #(
        .NUM_SEGS (NUM_SEGS),
        .SEG_W    (SEG_W)
    ) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cw_en),
        .widx   (cw_idx),
        .wvalid (cw_valid),
        .wsel   (cw_sel),
        .wdesc  (cw_desc),
        .ridx   (q_seg),
        .rvalid (q_valid),
        .rsel   (q_sel),
        .rdesc  (q_desc)
    );

    // outputs
    always_comb begin
        ld_ready   = (state == ST_IDLE);
        rd_valid   = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
        rd_addr    = (state == ST_FETCH_HI) ? (addr_q + 32'd4) : addr_q;
        done       = (state == ST_DONE);
        fault      = (flt_q != FLT_NONE);
        fault_code = flt_q;
        for (int i = 0; i < NUM_SEGS; i++)
            seg_busy[i] = (state != ST_IDLE) && !tgt_ldt_q && (tgt_seg_q == SEG_W'(i));
        q_base     = q_desc.base;
        q_limit    = span_of(q_desc);
        q_access   = q_desc.acc;
        q_gran     = q_desc.gran;
        q_dbit     = q_desc.dbit;
        q_avail    = q_desc.avail;
        ldt_valid  = ldt_valid_q;
        ldt_base   = ldt_base_q;
        ldt_limit  = ldt_limit_q;
    end

endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
    parameter int NUM_SEGS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_ready,
    input logic                rd_valid,
    input logic                rd_ready,
    input logic [31:0]         rd_addr,
    input logic                done,
    input logic                fault,
    input logic [2:0]          fault_code,
    input logic [NUM_SEGS-1:0] seg_busy
);

    // R2: a stalled read keeps its request and address
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R10: an idle engine issues no reads and marks nothing busy
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> (!rd_valid && (seg_busy == '0)));

    // R10: at most one segment busy while a load runs
    p_busy_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ready |-> $onehot0(seg_busy));

    // R12: completion lasts a single cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: fault flag agrees with the code
    p_fault_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_code != 3'd0)));

    // R10: completion is part of the busy window
    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ld_ready);

endmodule

bind seg_desc_loader sdl_checker #(.NUM_SEGS(NUM_SEGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_ready   (ld_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .seg_busy   (seg_busy)
);

// File: tb/sim_seg_desc_loader.sv
module sim_seg_desc_loader;

    localparam int NSEG = 4;
    localparam logic [31:0] GDT_AREA = 32'h0001_0000;
    localparam logic [31:0] LDT_AREA = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gdt_we;
    logic [31:0] gdt_base_in;
    logic [15:0] gdt_limit_in;
    logic        ld_valid;
    logic        ld_ready;
    logic        ld_to_ldt;
    logic [1:0]  ld_seg;
    logic [15:0] ld_sel;
    logic [1:0]  ld_cpl;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        done;
    logic        fault;
    logic [2:0]  fault_code;
    logic [NSEG-1:0] seg_busy;
    logic [1:0]  q_seg;
    logic        q_valid;
    logic [15:0] q_sel;
    logic [31:0] q_base;
    logic [31:0] q_limit;
    logic [7:0]  q_access;
    logic        q_gran;
    logic        q_dbit;
    logic        q_avail;
    logic        ldt_valid;
    logic [31:0] ldt_base;
    logic [31:0] ldt_limit;

    always #10 clk = ~clk;

    seg_desc_loader #(.NUM_SEGS(NSEG)) u0 (.*);

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    logic [7:0] lfsr = 8'hA5;

    // model state
    bit          m_v   [NSEG];
    logic [15:0] m_sel [NSEG];
    logic [31:0] m_base[NSEG];
    logic [31:0] m_lim [NSEG];
    logic [7:0]  m_acc [NSEG];
    bit          m_g[NSEG], m_d[NSEG], m_av[NSEG];
    logic [15:0] m_gdt_limit;
    bit          m_ldt_v;
    logic [31:0] m_ldt_base, m_ldt_lim;

    function automatic void desc_of(input int t, input int idx,
                                    output logic [31:0] b, output logic [19:0] l,
                                    output logic [7:0] a, output logic g,
                                    output logic d, output logic av);
        logic [1:0] dpl;
        bit pres;
        dpl  = 2'(idx);
        pres = (idx % 5) != 3;
        b  = 32'h0100_0000 * idx + 32'h0001_0203 * (idx + 1) + (t != 0 ? 32'h8000_0000 : 32'h0);
        l  = 20'(idx * 32'h1357 + 32'h00FF);
        a  = {pres, dpl, 5'b10010};
        g  = 1'((idx + t) % 2);
        d  = 1'((idx >> 1) % 2);
        av = 1'(((idx >> 2) + t) % 2);
        if (t == 0 && idx == 7) begin
            b = LDT_AREA; l = 20'd31; a = 8'h82; g = 0; d = 0; av = 0;
        end
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] adr);
        logic [31:0] b; logic [19:0] l; logic [7:0] a; logic g, d, av;
        int t, idx;
        if (adr >= GDT_AREA && adr < GDT_AREA + 32'h80) begin
            t = 0; idx = int'((adr - GDT_AREA) >> 3);
        end else if (adr >= LDT_AREA && adr < LDT_AREA + 32'h80) begin
            t = 1; idx = int'((adr - LDT_AREA) >> 3);
        end else begin
            return 32'hDEAD_BEEF;
        end
        desc_of(t, idx, b, l, a, g, d, av);
        if (adr[2] == 1'b0) return {b[15:0], l[15:0]};
        return {b[31:24], g, d, 1'b0, av, l[19:16], a, b[23:16]};
    endfunction

    always_comb rd_data = mem_word(rd_addr);

    // ready pattern; a handshake counted here happens at the next rising edge
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ready = lfsr[0] | lfsr[2];
        if (rd_valid && rd_ready) nreads++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_seg(input int s, input string req);
        q_seg = 2'(s);
        #1;
        chk(q_valid == m_v[s], req, "valid", 32'(q_valid), 32'(m_v[s]));
        chk(q_sel == m_sel[s], req, "selector", 32'(q_sel), 32'(m_sel[s]));
        chk(q_base == m_base[s], req, "base", q_base, m_base[s]);
        chk(q_limit == m_lim[s], req, "limit", q_limit, m_lim[s]);
        chk(q_access == m_acc[s], req, "access", 32'(q_access), 32'(m_acc[s]));
        chk({q_gran, q_dbit, q_avail} == {m_g[s], m_d[s], m_av[s]}, req, "flags",
            32'({q_gran, q_dbit, q_avail}), 32'({m_g[s], m_d[s], m_av[s]}));
    endtask

    task automatic do_load(input bit to_ldt, input int seg, input logic [15:0] sel,
                           input int cpl, input bit wr, input logic [15:0] new_lim);
        int idx, rpl, ecode, ereads, r0, cnt;
        bit ti, is_null;
        logic [31:0] b; logic [19:0] l; logic [7:0] a; logic g, d, av;
        logic [31:0] bound;
        string req;
        idx = int'(sel[15:3]); ti = sel[2]; rpl = int'(sel[1:0]);
        bound = 32'(idx * 8 + 7);
        desc_of(ti ? 1 : 0, idx, b, l, a, g, d, av);
        is_null = (idx == 0) && !ti;
        ecode = 0;
        if (to_ldt) begin
            if (ti) ecode = 5;
            else if (!is_null && bound > 32'(m_gdt_limit)) ecode = 2;
            else if (!is_null && !a[7]) ecode = 3;
        end else if (is_null) begin
            if (seg < 2) ecode = 1;
        end else begin
            if (ti ? (!m_ldt_v || bound > m_ldt_lim) : (bound > 32'(m_gdt_limit))) ecode = 2;
            else if (!a[7]) ecode = 3;
            else if (seg >= 2 && ((cpl > rpl ? cpl : rpl) > int'(a[6:5]))) ecode = 4;
        end
        ereads = (ecode == 0 || ecode == 3 || ecode == 4) && !is_null ? 2 : 0;

        @(negedge clk);
        while (!ld_ready) @(negedge clk);
        r0 = nreads;
        ld_valid = 1; ld_to_ldt = to_ldt; ld_seg = 2'(seg); ld_sel = sel; ld_cpl = 2'(cpl);
        gdt_we = wr; gdt_limit_in = new_lim; gdt_base_in = GDT_AREA;
        @(negedge clk);
        ld_valid = 0; gdt_we = 0;
        chk(seg_busy == (to_ldt ? 4'b0 : 4'(1 << seg)), "R10", "busy",
            32'(seg_busy), to_ldt ? 32'h0 : 32'(1 << seg));
        chk(!ld_ready, "R10", "ready low", 32'(ld_ready), 32'h0);
        cnt = 0;
        while (!done && cnt < 100) begin @(negedge clk); cnt++; end
        chk(done, "R12", "done seen", 32'(done), 32'h1);
        case (ecode)
            0: req = "R3"; 1: req = "R4"; 2: req = "R5";
            3: req = "R6"; 4: req = "R7"; default: req = "R9";
        endcase
        chk(32'(fault_code) == 32'(ecode), req, "fault code", 32'(fault_code), 32'(ecode));
        chk(fault == (ecode != 0), "R12", "fault flag", 32'(fault), 32'(ecode != 0));
        chk(nreads - r0 == ereads, "R2", "read count", 32'(nreads - r0), 32'(ereads));

        if (ecode == 0) begin
            if (to_ldt) begin
                m_ldt_v = !is_null;
                m_ldt_base = is_null ? 32'h0 : b;
                m_ldt_lim  = is_null ? 32'h0 : (g ? {l, 12'hFFF} : {12'h0, l});
            end else begin
                m_v[seg] = !is_null; m_sel[seg] = sel;
                m_base[seg] = is_null ? 32'h0 : b;
                m_lim[seg]  = is_null ? 32'h0 : (g ? {l, 12'hFFF} : {12'h0, l});
                m_acc[seg]  = is_null ? 8'h0 : a;
                m_g[seg] = is_null ? 1'b0 : g; m_d[seg] = is_null ? 1'b0 : d;
                m_av[seg] = is_null ? 1'b0 : av;
            end
        end
        if (wr) m_gdt_limit = new_lim;
        if (to_ldt) begin
            chk(ldt_valid == m_ldt_v, "R9", "ldt valid", 32'(ldt_valid), 32'(m_ldt_v));
            chk(ldt_base == m_ldt_base, "R9", "ldt base", ldt_base, m_ldt_base);
            chk(ldt_limit == m_ldt_lim, "R9", "ldt limit", ldt_limit, m_ldt_lim);
        end else begin
            check_seg(seg, ecode == 0 ? req : "R8");
        end
        @(negedge clk);
        chk(!done, "R12", "single pulse", 32'(done), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dones;
        rst_n = 0; gdt_we = 0; gdt_base_in = 0; gdt_limit_in = 0;
        ld_valid = 0; ld_to_ldt = 0; ld_seg = 0; ld_sel = 0; ld_cpl = 0; q_seg = 0;
        rd_ready = 1;
        for (int s = 0; s < NSEG; s++) begin
            m_v[s] = 0; m_sel[s] = 0; m_base[s] = 0; m_lim[s] = 0; m_acc[s] = 0;
            m_g[s] = 0; m_d[s] = 0; m_av[s] = 0;
        end
        m_gdt_limit = 0; m_ldt_v = 0; m_ldt_base = 0; m_ldt_lim = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ld_ready && !done && !rd_valid && seg_busy == 0 && !ldt_valid, "R1", "idle outputs",
            {27'h0, ld_ready, done, rd_valid, |seg_busy, ldt_valid}, 32'h10);
        for (int s = 0; s < NSEG; s++) check_seg(s, "R1");

        // program the global table
        gdt_we = 1; gdt_base_in = GDT_AREA; gdt_limit_in = 16'd63;
        @(negedge clk);
        gdt_we = 0; m_gdt_limit = 16'd63;

        // global sweep: R3..R8 with index 8,9 past the limit
        for (int i = 0; i < 10; i++)
            for (int s = 0; s < NSEG; s++)
                for (int c = 0; c < 4; c++)
                    for (int r = 0; r < 4; r++)
                        do_load(0, s, {13'(i), 1'b0, 2'(r)}, c, 0, 16'h0);

        // local table: R5 before load, R9 register loads
        do_load(0, 2, {13'd1, 1'b1, 2'd0}, 0, 0, 16'h0);
        do_load(1, 0, {13'd7, 1'b1, 2'd0}, 0, 0, 16'h0);
        do_load(1, 0, {13'd9, 1'b0, 2'd0}, 0, 0, 16'h0);
        do_load(1, 0, {13'd3, 1'b0, 2'd0}, 0, 0, 16'h0);
        do_load(1, 0, {13'd7, 1'b0, 2'd0}, 0, 0, 16'h0);
        for (int i = 0; i < 6; i++)
            for (int s = 0; s < NSEG; s++)
                for (int r = 0; r < 4; r++)
                    do_load(0, s, {13'(i), 1'b1, 2'(r)}, 1, 0, 16'h0);
        do_load(1, 0, 16'h0000, 0, 0, 16'h0);
        do_load(0, 3, {13'd1, 1'b1, 2'd0}, 0, 0, 16'h0);

        // R11: table write in the acceptance cycle
        do_load(0, 2, {13'd5, 1'b0, 2'd0}, 0, 1, 16'd7);
        do_load(0, 2, {13'd5, 1'b0, 2'd0}, 0, 0, 16'h0);
        do_load(0, 2, {13'd5, 1'b0, 2'd0}, 0, 1, 16'd63);
        do_load(0, 2, {13'd5, 1'b0, 2'd0}, 0, 0, 16'h0);

        // R10: request during a running load is ignored
        @(negedge clk);
        while (!ld_ready) @(negedge clk);
        ld_valid = 1; ld_to_ldt = 0; ld_seg = 2'd3; ld_sel = {13'd2, 1'b0, 2'd0}; ld_cpl = 0;
        @(negedge clk);
        ld_seg = 2'd1; ld_sel = {13'd4, 1'b0, 2'd0};
        @(negedge clk);
        ld_valid = 0;
        dones = 0;
        repeat (30) begin
            if (done) dones++;
            @(negedge clk);
        end
        chk(dones == 1, "R10", "completions", 32'(dones), 32'h1);
        begin
            logic [31:0] b; logic [19:0] l; logic [7:0] a; logic g, d, av;
            desc_of(0, 2, b, l, a, g, d, av);
            m_v[3] = 1; m_sel[3] = {13'd2, 1'b0, 2'd0}; m_base[3] = b;
            m_lim[3] = g ? {l, 12'hFFF} : {12'h0, l}; m_acc[3] = a;
            m_g[3] = g; m_d[3] = d; m_av[3] = av;
        end
        check_seg(3, "R10");
        check_seg(1, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule